// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block holds the single atomic-update reservation of one processor. When the load/store side issues a load-reserve, the block records the word granule of its address and marks the reservation valid. Stores from other bus masters are observed on a snoop port. A snooped store that lands in the reserved granule destroys the reservation and raises a one-cycle loss notice back to the load/store side.

A store-conditional is resolved in the same cycle it is presented. If a valid reservation covers its granule, the write is forwarded to the bus and success is reported. Otherwise the bus write is withheld and failure is reported. Any store-conditional without an alignment fault ends the reservation. A faulting store-conditional is refused and leaves the reservation untouched. A snooped store in the same cycle is treated as having happened first.

Top module: `rsv_tracker`

## Requirements
- R1: After reset no reservation is held, so a store-conditional issued before any load-reserve reports failure (`sc_done`=1, `sc_pass`=0) and `bus_wr_req` stays 0.
- R2: A load-reserve records its address. A following store-conditional to that granule drives `bus_wr_req`=1 with `bus_wr_addr`/`bus_wr_data` equal to `sc_addr`/`sc_wdata`, and `sc_pass`=1, all in the request cycle.
- R3: Granule matching uses address bits [31:2] only. Two addresses that differ only in bits [1:0] match.
- R4: A new load-reserve replaces the held reservation even while the old one is valid. A store-conditional to the old granule then fails.
- R5: A snooped store to the reserved granule pulses `rsv_lost` in that cycle and clears the reservation. A snooped store to any other granule changes nothing.
- R6: A store-conditional with no valid reservation keeps `bus_wr_req` at 0 and reports failure.
- R7: A store-conditional without an alignment fault clears the reservation, whether it passes or fails.
- R8: A store-conditional with `sc_align_fault`=1 reports failure, issues no bus write, and leaves the reservation unchanged.
- R9: A store-conditional to a granule other than the reserved one fails and clears the reservation.
- R10: When a load-reserve and a snooped store to the held granule arrive in the same cycle, the load-reserve wins and the new reservation is valid afterward.
- R11: A snooped store that hits the reserved granule in the same cycle as a store-conditional to that granule makes the store-conditional fail.
- R12: `sc_done` is 1 exactly in the cycles where `sc_req` is 1, and `sc_pass` is never 1 without `sc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | 1 | Load-reserve address phase completes |
| lr_addr | input | 32 | Load-reserve address |
| snp_store | input | 1 | Store by another master observed |
| snp_addr | input | 32 | Address of the snooped store |
| sc_req | input | 1 | Store-conditional granted this cycle |
| sc_addr | input | 32 | Store-conditional address |
| sc_wdata | input | 32 | Store-conditional write data |
| sc_align_fault | input | 1 | Store-conditional raised an alignment fault |
| bus_wr_req | output | 1 | Forwarded write request |
| bus_wr_addr | output | 32 | Forwarded write address |
| bus_wr_data | output | 32 | Forwarded write data |
| sc_done | output | 1 | Store-conditional resolved this cycle |
| sc_pass | output | 1 | Store-conditional succeeded |
| rsv_lost | output | 1 | Reservation destroyed by a snooped store |

## Verification
The reservation flag and granule cannot be read directly. A stale or wrongly cleared reservation shows up at the next store-conditional as a wrong `sc_pass` and a missing or extra `bus_wr_req`. It also shows up at the next matching snoop as a missing or extra `rsv_lost`. Each sequence therefore ends with a store-conditional one cycle after the event under test, so that a state fault appears within one to two cycles. A reference model compares every output in every cycle, including during random mixed traffic.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    parameter int ADDR_W   = 32;
    parameter int DATA_W   = 32;
    parameter int GRAN_LSB = 2;
    parameter int N_CMP    = 2;
    localparam int TAG_W   = ADDR_W - GRAN_LSB;
    localparam int CMP_SNP = 0;
    localparam int CMP_SC  = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  gran_t;

    typedef struct packed {
        logic  valid;
        gran_t tag;
    } rsv_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_e;

    function automatic gran_t gran_of(input addr_t a);
        return a[ADDR_W-1:GRAN_LSB];
    endfunction
endpackage

// File: rtl/rsv_granule_cmp.sv
module rsv_granule_cmp
    import rsv_pkg::*;
(
    input  rsv_t  held,
    input  logic  probe,
    input  addr_t addr,
    output logic  hit
);
    logic unused_low;
    assign unused_low = ^addr[GRAN_LSB-1:0];
    assign hit = probe && held.valid && (held.tag == gran_of(addr));
endmodule

// File: rtl/rsv_reg.sv
module rsv_reg
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  upd_e  op,
    input  gran_t new_tag,
    output rsv_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                UPD_LOAD:  q <= '{valid: 1'b1, tag: new_tag};
                UPD_CLEAR: q.valid <= 1'b0;
                default:   q <= q;
            endcase
        end
    end

    // R10 / R4: a load always leaves a valid reservation on the new granule
    a_r10_load_sets_valid: assert property (@(posedge clk) disable iff (rst)
        op == UPD_LOAD |=> (q.valid && q.tag == $past(new_tag)));

    // R7: a clear leaves no reservation
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        op == UPD_CLEAR |=> !q.valid);

    // R8: a hold keeps state stable
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        op == UPD_HOLD |=> $stable(q));
endmodule

// File: rtl/rsv_sc_ctrl.sv
module rsv_sc_ctrl
    import rsv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rsv_t held,
    input  logic lr_req,
    input  logic sc_req,
    input  logic sc_align_fault,
    input  logic snp_hit,
    input  logic sc_hit,
    output upd_e op,
    output logic wr_req,
    output logic done,
    output logic pass,
    output logic lost
);
    always_comb begin
        wr_req = sc_req && !sc_align_fault && sc_hit && !snp_hit;
        done   = sc_req;
        pass   = wr_req;
        lost   = snp_hit;
        if (lr_req)
            op = UPD_LOAD;
        else if (sc_req && !sc_align_fault)
            op = UPD_CLEAR;
        else if (snp_hit)
            op = UPD_CLEAR;
        else
            op = UPD_HOLD;
    end

    // R6: a forwarded write needs a held reservation
    a_r6_write_needs_valid: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> held.valid);

    // R8: a faulting store-conditional never writes
    a_r8_fault_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (sc_req && sc_align_fault) |-> !wr_req);

    // R12: success only with completion
    a_r12_pass_with_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    // R11: a same-cycle snoop hit defeats the store-conditional
    a_r11_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_hit |-> !wr_req);
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lr_req,
    input  logic [rsv_pkg::ADDR_W-1:0] lr_addr,
    input  logic                     snp_store,
    input  logic [rsv_pkg::ADDR_W-1:0] snp_addr,
    input  logic                     sc_req,
    input  logic [rsv_pkg::ADDR_W-1:0] sc_addr,
    input  logic [rsv_pkg::DATA_W-1:0] sc_wdata,
    input  logic                     sc_align_fault,
    output logic                     bus_wr_req,
    output logic [rsv_pkg::ADDR_W-1:0] bus_wr_addr,
    output logic [rsv_pkg::DATA_W-1:0] bus_wr_data,
    output logic                     sc_done,
    output logic                     sc_pass,
    output logic                     rsv_lost
);
    rsv_t  held;
    upd_e  op;
    logic  lr_low_unused;
    logic  [N_CMP-1:0] probe_v;
    addr_t             probe_a [N_CMP];
    logic  [N_CMP-1:0] hit_v;

    assign lr_low_unused = ^lr_addr[GRAN_LSB-1:0];

    assign probe_v[CMP_SNP] = snp_store;
    assign probe_a[CMP_SNP] = snp_addr;
    assign probe_v[CMP_SC]  = sc_req;
    assign probe_a[CMP_SC]  = sc_addr;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        rsv_granule_cmp i_cmp (
            .held  (held),
            .probe (probe_v[g]),
            .addr  (probe_a[g]),
            .hit   (hit_v[g])
        );
    end

    rsv_sc_ctrl i_ctrl (
        .clk            (clk),
        .rst            (rst),
        .held           (held),
        .lr_req         (lr_req),
        .sc_req         (sc_req),
        .sc_align_fault (sc_align_fault),
        .snp_hit        (hit_v[CMP_SNP]),
        .sc_hit         (hit_v[CMP_SC]),
        .op             (op),
        .wr_req         (bus_wr_req),
        .done           (sc_done),
        .pass           (sc_pass),
        .lost           (rsv_lost)
    );

    rsv_reg i_reg (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .new_tag (gran_of(lr_addr)),
        .q       (held)
    );

    assign bus_wr_addr = sc_addr;
    assign bus_wr_data = sc_wdata;

    // R5: a loss notice is followed by no reservation unless a load-reserve replaced it
    a_r5_lost_clears: assert property (@(posedge clk) disable iff (rst)
        (rsv_lost && !lr_req) |=> !held.valid);

    // R1: a freshly reset tracker holds nothing
    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> !held.valid);
endmodule

// File: tb/test_rsv_tracker.sv
module test_rsv_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lr_req = 0, snp_store = 0, sc_req = 0, sc_align_fault = 0;
    logic [31:0] lr_addr = 0, snp_addr = 0, sc_addr = 0, sc_wdata = 0;
    logic        bus_wr_req, sc_done, sc_pass, rsv_lost;
    logic [31:0] bus_wr_addr, bus_wr_data;

    int checks = 0;
    int errors = 0;
    bit          m_valid = 0;
    logic [29:0] m_tag = '0;

    always #2 clk = ~clk;

    rsv_tracker i_rsv_tracker (
        .clk(clk), .rst(rst),
        .lr_req(lr_req), .lr_addr(lr_addr),
        .snp_store(snp_store), .snp_addr(snp_addr),
        .sc_req(sc_req), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
        .sc_align_fault(sc_align_fault),
        .bus_wr_req(bus_wr_req), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .sc_done(sc_done), .sc_pass(sc_pass), .rsv_lost(rsv_lost)
    );

    task automatic step(input bit lr, input logic [31:0] la,
                        input bit sn, input logic [31:0] sa,
                        input bit sc, input logic [31:0] ca,
                        input bit flt, input logic [31:0] d, input string req);
        bit hs, hc, e_pass;
        logic [5:0] act, exp_v;
        lr_req = lr; lr_addr = la; snp_store = sn; snp_addr = sa;
        sc_req = sc; sc_addr = ca; sc_align_fault = flt; sc_wdata = d;
        #1;
        hs = sn && m_valid && (sa[31:2] == m_tag);
        hc = sc && m_valid && (ca[31:2] == m_tag);
        e_pass = sc && !flt && hc && !hs;
        act   = {bus_wr_req, sc_done, sc_pass, rsv_lost,
                 bus_wr_req ? (bus_wr_addr == ca) : 1'b1,
                 bus_wr_req ? (bus_wr_data == d)  : 1'b1};
        exp_v = {e_pass, sc, e_pass, hs, 1'b1, 1'b1};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: {wr,done,pass,lost,addr_ok,data_ok} actual %b expected %b",
                     req, act, exp_v);
        end
        @(posedge clk);
        if (lr) begin m_valid = 1; m_tag = la[31:2]; end
        else if (sc && !flt) m_valid = 0;
        else if (hs) m_valid = 0;
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle("R12");
        // R1: store-conditional before any load-reserve
        step(0,0, 0,0, 1,32'h100, 0,32'hA1, "R1");
        // R2: plain pass
        step(1,32'h100, 0,0, 0,0, 0,0, "R2");
        step(0,0, 0,0, 1,32'h100, 0,32'hDEAD0001, "R2");
        // R7: success consumed the reservation
        step(0,0, 0,0, 1,32'h100, 0,32'hB2, "R7");
        // R3: low bits ignored
        step(1,32'h200, 0,0, 0,0, 0,0, "R3");
        step(0,0, 0,0, 1,32'h203, 0,32'hC3, "R3");
        // R4: replacement
        step(1,32'h300, 0,0, 0,0, 0,0, "R4");
        step(1,32'h400, 0,0, 0,0, 0,0, "R4");
        step(0,0, 0,0, 1,32'h300, 0,32'hD4, "R4");
        step(1,32'h400, 0,0, 0,0, 0,0, "R4");
        step(0,0, 0,0, 1,32'h400, 0,32'hE4, "R4");
        // R5: snoop miss then hit
        step(1,32'h500, 0,0, 0,0, 0,0, "R5");
        step(0,0, 1,32'h504, 0,0, 0,0, "R5");
        step(0,0, 1,32'h502, 0,0, 0,0, "R5");
        step(0,0, 0,0, 1,32'h500, 0,32'hF5, "R5");
        // R6: no reservation, no write
        step(0,0, 0,0, 1,32'h500, 0,32'h16, "R6");
        // R8: alignment fault keeps reservation
        step(1,32'h600, 0,0, 0,0, 0,0, "R8");
        step(0,0, 0,0, 1,32'h600, 1,32'h18, "R8");
        step(0,0, 0,0, 1,32'h600, 0,32'h28, "R8");
        // R9: mismatched address fails and clears
        step(1,32'h700, 0,0, 0,0, 0,0, "R9");
        step(0,0, 0,0, 1,32'h704, 0,32'h19, "R9");
        step(0,0, 0,0, 1,32'h700, 0,32'h29, "R9");
        // R10: load-reserve beats same-cycle snoop hit
        step(1,32'h800, 0,0, 0,0, 0,0, "R10");
        step(1,32'h800, 1,32'h800, 0,0, 0,0, "R10");
        step(0,0, 0,0, 1,32'h800, 0,32'h1A, "R10");
        // R11: snoop hit in same cycle as store-conditional
        step(1,32'h900, 0,0, 0,0, 0,0, "R11");
        step(0,0, 1,32'h900, 1,32'h900, 0,32'h1B, "R11");
        step(0,0, 0,0, 1,32'h900, 0,32'h2B, "R11");
        idle("R12");
        // R12: mixed traffic over a small address pool
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], {26'h0, r[5:4], 4'h0} | {30'h0, r[7:6]},
                 r[1], {26'h0, r[9:8], 4'h0},
                 r[2], {26'h0, r[11:10], 4'h0} | {30'h0, r[13:12]},
                 r[3] & r[14], $urandom, "R12");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule